// File: doc/BRIEF.md
# Data-Link Mode-Switching Message Receiver

This block sits on the serial data-link channel of a line framer. It takes one bit per strobe and decides whether the link is carrying HDLC frames or repeated 16-bit bit-oriented message (BOM) codewords. It also extracts the 6-bit message code from each codeword. Each of the two receivers has its own enable. With both enabled, the block moves into message mode by itself after a long run of ones, and back to HDLC mode when it sees a flag. With only the message receiver enabled, it stays in message mode.

Codes that pass the selected acceptance rule are reported with a one-cycle pulse. They are also queued as bytes in a 64-entry receive FIFO that the host drains through a first-word-fall-through read port. The block does not decode HDLC frame contents beyond flag recognition.

There are three acceptance rules:
- every codeword is taken;
- a code is taken only when it differs from the last code taken;
- a code is taken only once it fills at least 7 of the 10 most recent codeword slots, and it differs from the last code taken.

Top module: `dl_msg_rx`

## Requirements
- R1: After reset, `msg_mode` is 0, `fifo_empty` is 1, `fifo_level` is 0, `fifo_ovf` is 0 and `code_vld` is 0.
- R2: With `msg_en` low, `msg_mode` stays 0 and no code is ever reported, even after sixteen or more ones and well-formed codewords.
- R3: With `msg_en` high and `hdlc_en` low, `msg_mode` is 1 from the cycle after the enables are applied. A flag (0x7E) does not clear it.
- R4: With both enables high, `msg_mode` rises on the clock edge that samples the eighth consecutive one. Flags alone never set it.
- R5: With both enables high and `msg_mode` at 1, a completed flag 01111110 returns `msg_mode` to 0. A completed codeword takes priority over a flag that ends on the same bit, so payload 0x3F is accepted and the block stays in message mode.
- R6: While `msg_mode` is 1, a codeword is recognised when the last 16 bits received, first bit first, are 11111111, then 0, then six payload bits, then 0. The code is the payload with its first-received bit as code bit 5. `code_vld` pulses for one cycle after the final bit's edge, with `code` holding the value.
- R7: With `acc_mode` = 0, every recognised codeword is accepted, including repeats.
- R8: With `acc_mode` = 1, a codeword is accepted only when its code differs from the last accepted code. The first code in message mode is always accepted.
- R9: With `acc_mode` = 2 or 3, a codeword is accepted when its code occupies at least 7 of the last 10 codeword slots, counting itself, and differs from the last accepted code. A stable code is therefore reported exactly once.
- R10: The codeword history and the last accepted code are forgotten whenever `msg_mode` is 0.
- R11: Each accepted code is written to the FIFO as the byte {2'b00, code}. `rd_data` shows the oldest entry whenever `fifo_empty` is 0. `rd_en` pops it. `fifo_level` counts the entries, up to 64.
- R12: An accepted code that meets a full FIFO is dropped and sets `fifo_ovf`, which stays 1 until reset. The pulse on `code_vld` is still given and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdlc_en | input | 1 | HDLC receiver enable |
| msg_en | input | 1 | Message receiver enable |
| acc_mode | input | 2 | Acceptance rule: 0 all, 1 on change, 2/3 7-of-10 |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new line bit |
| bit_in | input | 1 | Received data-link bit |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head byte |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_level | output | 7 | Number of stored entries |
| fifo_ovf | output | 1 | Sticky overflow indication |
| msg_mode | output | 1 | 1 = message mode, 0 = HDLC mode |
| code_vld | output | 1 | One-cycle pulse for an accepted code |
| code | output | 6 | Last accepted code |

## Verification
The bench uses a history made of a non-consecutive majority (four of a code, a stranger, then three more). A design that demands seven equal codes in a row, or counts the stranger, would report that code late or never.

It leaves message mode with six matching codes in the history, re-enters, and expects no report on the next match. A design that keeps stale history would report at once.

It also sends payload 0x3F, whose low byte looks like a flag. A design that lets the flag win would drop to HDLC mode and lose the code.

The overflow case writes 65 codes. A design that wraps its pointers would overwrite the oldest entry or lose the sticky flag.

// File: rtl/dl_msg_rx.sv
module dl_msg_rx #(
  parameter int DEPTH  = 64,
  parameter int HIST   = 10,
  parameter int THRESH = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdlc_en,
  input  logic       msg_en,
  input  logic [1:0] acc_mode,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       fifo_empty,
  output logic [6:0] fifo_level,
  output logic       fifo_ovf,
  output logic       msg_mode,
  output logic       code_vld,
  output logic [5:0] code
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(HIST + 1);

  logic [15:0]   sh;
  logic [3:0]    ones;
  logic [5:0]    hist [HIST];
  logic [HIST-1:0] hv;
  logic [5:0]    last_code;
  logic          last_vld;
  logic [CW-1:0] hits;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  wire [15:0] nsh   = {sh[14:0], bit_in};
  wire        ones8 = bit_in && (ones >= 4'd7);
  wire        flag  = (nsh[7:0] == 8'h7E);
  wire        cw    = bit_vld && msg_mode && (nsh[15:8] == 8'hFF) && !nsh[7] && !nsh[0];
  wire [5:0]  ncode = nsh[6:1];
  wire        novel = !last_vld || (last_code != ncode);
  wire        major = (32'(hits) + 1) >= THRESH;
  wire        accept = cw && (acc_mode == 2'd0 ? 1'b1 :
                              acc_mode == 2'd1 ? novel : (novel && major));
  wire        full  = (32'(fifo_level) == DEPTH);
  wire        wr    = accept && !full;
  wire        rd    = rd_en && !fifo_empty;
  wire        mode_d = !msg_en  ? 1'b0 :
                       !hdlc_en ? 1'b1 :
                       !bit_vld ? msg_mode :
                       msg_mode ? !(flag && !cw) : ones8;

  assign fifo_empty = (fifo_level == '0);
  assign rd_data    = mem[rp];

  always_comb begin
    hits = '0;
    for (int i = 0; i < HIST - 1; i++)
      if (hv[i] && hist[i] == ncode) hits = hits + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      ones <= '0;
      msg_mode <= 1'b0;
      hv <= '0;
      last_vld <= 1'b0;
      last_code <= '0;
      code_vld <= 1'b0;
      code <= '0;
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else begin
      msg_mode <= mode_d;
      code_vld <= accept;
      if (accept) code <= ncode;
      if (bit_vld) begin
        sh <= nsh;
        ones <= !bit_in ? 4'd0 : (ones == 4'd8) ? ones : ones + 4'd1;
      end
      if (!msg_mode) begin
        hv <= '0;
        last_vld <= 1'b0;
      end else if (cw) begin
        hist[0] <= ncode;
        for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        hv <= {hv[HIST-2:0], 1'b1};
        if (accept) begin
          last_code <= ncode;
          last_vld <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      fifo_level <= '0;
      fifo_ovf <= 1'b0;
    end else begin
      if (wr) wp <= wp + AW'(1);
      if (rd) rp <= rp + AW'(1);
      fifo_level <= fifo_level + 7'(wr) - 7'(rd);
      if (accept && full) fifo_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[wp] <= {2'b00, ncode};
endmodule

// File: rtl/dl_msg_rx_chk.sv
module dl_msg_rx_chk #(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hdlc_en,
  input logic       msg_en,
  input logic       bit_vld,
  input logic       rd_en,
  input logic [6:0] fifo_level,
  input logic       fifo_empty,
  input logic       fifo_ovf,
  input logic       msg_mode,
  input logic       code_vld
);
  assert_msg_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_en |=> !msg_mode);
  assert_msg_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_en && !hdlc_en) |=> msg_mode);
  assert_pulse_needs_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |-> $past(bit_vld));
  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= DEPTH);
  assert_level_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_level) <= 32'($past(fifo_level)) + 1);
  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !code_vld) |=> fifo_level <= 7'd1);
  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);
  assert_ovf_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_ovf) |-> 32'(fifo_level) >= DEPTH - 1);
endmodule

bind dl_msg_rx dl_msg_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdlc_en(hdlc_en), .msg_en(msg_en),
  .bit_vld(bit_vld), .rd_en(rd_en), .fifo_level(fifo_level),
  .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf), .msg_mode(msg_mode),
  .code_vld(code_vld)
);

// File: tb/sim_dl_msg_rx.sv
module sim_dl_msg_rx;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic hdlc_en = 1, msg_en = 1, bit_vld = 0, bit_in = 0, rd_en = 0;
  logic [1:0] acc_mode = 0;
  logic [7:0] rd_data;
  logic fifo_empty, fifo_ovf, msg_mode, code_vld;
  logic [6:0] fifo_level;
  logic [5:0] code;

  int nchk = 0, nfail = 0;
  string cur_req = "R6";
  logic [5:0] exp_q[$];
  logic [7:0] fq[$];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dl_msg_rx u0 (.*);

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && code_vld) begin
    if (exp_q.size() == 0) check({cur_req, " unexpected code"}, code, -1);
    else check({cur_req, " code"}, code, exp_q.pop_front());
  end

  task automatic send_bit(logic b);
    @(negedge clk); bit_vld = 1; bit_in = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bit_vld = 0; bit_in = 0; end
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_cw(logic [5:0] c, bit exp);
    logic [15:0] w = {8'hFF, 1'b0, c, 1'b0};
    if (exp) begin
      exp_q.push_back(c);
      if (fq.size() < 64) fq.push_back({2'b00, c});
    end
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic drain(string req);
    idle(2);
    while (fq.size() > 0) begin
      @(negedge clk);
      check({req, " rd_data"}, rd_data, fq.pop_front());
      rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
    idle(1);
    check({req, " empty after drain"}, fifo_empty, 1);
  endtask

  task automatic exit_flag(string req);
    send_byte(8'h7E); idle(2);
    check({req, " back to HDLC"}, msg_mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 mode", msg_mode, 0);
    check("R1 empty", fifo_empty, 1);
    check("R1 level", fifo_level, 0);
    check("R1 ovf", fifo_ovf, 0);
    check("R1 valid", code_vld, 0);

    cur_req = "R7";
    send_byte(8'h7E); send_byte(8'h7E); idle(1);
    check("R4 flags keep HDLC", msg_mode, 0);
    send_cw(6'h15, 1); idle(1);
    check("R4 entered message mode", msg_mode, 1);
    send_cw(6'h2A, 1); send_cw(6'h15, 1); idle(2);
    check("R11 level", fifo_level, 3);
    cur_req = "R5";
    send_cw(6'h3F, 1); idle(2);
    check("R5 codeword beats flag", msg_mode, 1);
    exit_flag("R5");
    drain("R11");

    cur_req = "R8"; acc_mode = 2'd1;
    send_cw(6'h15, 1); send_cw(6'h15, 0); send_cw(6'h15, 0);
    send_cw(6'h2A, 1); send_cw(6'h2A, 0); send_cw(6'h15, 1);
    exit_flag("R8");
    drain("R8");

    cur_req = "R9"; acc_mode = 2'd2;
    for (int i = 0; i < 6; i++) send_cw(6'h0F, 0);
    send_cw(6'h0F, 1); send_cw(6'h0F, 0); send_cw(6'h0F, 0);
    for (int i = 0; i < 6; i++) send_cw(6'h33, 0);
    send_cw(6'h33, 1);
    exit_flag("R9");
    for (int i = 0; i < 4; i++) send_cw(6'h01, 0);
    send_cw(6'h3C, 0);
    send_cw(6'h01, 0); send_cw(6'h01, 0); send_cw(6'h01, 1);
    exit_flag("R9");
    drain("R9");

    cur_req = "R10";
    for (int i = 0; i < 6; i++) send_cw(6'h0F, 0);
    exit_flag("R10");
    send_cw(6'h0F, 0); idle(2);
    check("R10 stale history ignored", fifo_level, 0);
    for (int i = 0; i < 5; i++) send_cw(6'h0F, 0);
    send_cw(6'h0F, 1);
    exit_flag("R10");
    drain("R10");

    cur_req = "R2"; acc_mode = 2'd0; msg_en = 0;
    send_byte(8'hFF); send_byte(8'hFF);
    send_cw(6'h15, 0); idle(2);
    check("R2 mode stays HDLC", msg_mode, 0);
    check("R2 no entry", fifo_level, 0);

    cur_req = "R3"; msg_en = 1; hdlc_en = 0; idle(2);
    check("R3 message mode forced", msg_mode, 1);
    send_byte(8'h7E); idle(1);
    check("R3 flag ignored", msg_mode, 1);
    send_cw(6'h21, 1); idle(2);
    check("R3 level", fifo_level, 1);
    drain("R3");
    hdlc_en = 1;
    exit_flag("R3");

    cur_req = "R12";
    for (int i = 0; i < 65; i++) send_cw(6'(i), 1);
    idle(2);
    check("R12 level full", fifo_level, 64);
    check("R12 ovf set", fifo_ovf, 1);
    drain("R12");
    check("R12 ovf sticky", fifo_ovf, 1);
    check("R7 all codes reported", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule